// File: doc/BRIEF.md
# Ultra DMA Host Burst Terminator

This block is the host-side sequencer that closes an Ultra DMA data-out burst. The data-transfer logic owns the host strobe and the acknowledge while words are moving. When a terminate request is accepted, this block takes over. It freezes the strobe, waits a setup time and raises STOP. It then waits for the device to withdraw its request (DMARQ) and its ready (DDMARDY, active low). Next it parks the strobe high, drives the 16-bit CRC with the bus output enable set, and finally negates the active-low acknowledge.

All minimum delays are counted in clock cycles through parameters. The two parameters `TMLI` and `TDVS` share a single crossing window, which lasts the larger of the two. Every "within" obligation is met by acting on the very next clock edge. A device that never withdraws DMARQ is caught by a timeout. The timeout raises a sticky flag, and the sequence still runs to completion. After the release cycle the block returns to idle and hands the strobe and acknowledge back to the transfer logic.

Top module: `udma_host_term`

## Requirements
- R1: After reset, with `xfer_ack` and `xfer_strobe` low, the outputs are `hstrobe`=0, `stop`=0, `dmack_n`=1, `dout_oe`=0, `dout`=0, `done`=0 and `dev_timeout`=0.
- R2: A `term_req` is taken only at a clock edge where the block is idle and `xfer_ack`=1. At any other time it is ignored, and the outputs keep following the idle pass-through.
- R3: From the edge that takes the request until the return to idle, `hstrobe` never falls. It holds the level that `xfer_strobe` had at that edge, and changes on `xfer_strobe` are ignored.
- R4: `stop` rises exactly `TSS` clock edges after the accepting edge. It stays high through the release cycle.
- R5: While `stop` is high and the device phase is active, the first edge that samples `dmarq`=0 and `ddmardy_n`=1 ends the device wait. From that edge on, `hstrobe` is 1.
- R6: On leaving the device wait, the value of `crc_in` is captured. It is then driven on `dout` with `dout_oe`=1 for exactly max(`TMLI`,`TDVS`) cycles, and `dout` is 0 whenever `dout_oe`=0.
- R7: The cycle after the CRC window is the release cycle. In it `dmack_n`=1, `dout_oe`=0, `stop`=1, `hstrobe`=1 and `done`=1, and `done` lasts exactly one cycle.
- R8: If `TMO` edges pass in the device wait without the device withdrawing, `dev_timeout` becomes 1 and the sequence continues as in R6 and R7. `dev_timeout` stays 1 until reset. A withdrawal sampled on the same edge as the limit takes priority and sets no flag.
- R9: When idle, `stop`=0, `hstrobe` equals `xfer_strobe` and `dmack_n` equals the inverse of `xfer_ack`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| term_req | input | 1 | Request to end the current burst |
| xfer_ack | input | 1 | Transfer logic is holding the acknowledge |
| xfer_strobe | input | 1 | Strobe level from the transfer logic |
| dmarq | input | 1 | Device DMA request, active high |
| ddmardy_n | input | 1 | Device ready, active low |
| crc_in | input | DW | Running CRC of the burst |
| hstrobe | output | 1 | Host strobe line |
| stop | output | 1 | STOP line, active high |
| dmack_n | output | 1 | Acknowledge, active low |
| dout | output | DW | Data bus value |
| dout_oe | output | 1 | Data bus output enable |
| done | output | 1 | One-cycle pulse in the release cycle |
| dev_timeout | output | 1 | Sticky flag: device did not withdraw in time |

## Verification
The hardest situations to reach are those that depend on the device's timing relative to the block's own counters. These are a device that never withdraws DMARQ, so the timeout path must run to release, and a device whose two withdrawals arrive in either order with varied gaps. The stimulus reaches both by scripting the device from the bench. Each burst gets randomly drawn delays for the two withdrawals and a random order between them, and one dedicated burst holds DMARQ high until the release. Further bursts start the termination with the strobe at either level, and they toggle `xfer_strobe` and pulse `term_req` again after acceptance. These cover the parking edge and the ignore rules.

// File: rtl/udma_term_pkg.sv
package udma_term_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HOLD = 3'd1,
    ST_WDEV = 3'd2,
    ST_CRC  = 3'd3,
    ST_REL  = 3'd4
  } term_st_e;

  // Length of the CRC window: both minimums are counted from the same edge.
  function automatic int crc_window(input int tmli, input int tdvs);
    int m;
    m = (tmli > tdvs) ? tmli : tdvs;
    return (m < 1) ? 1 : m;
  endfunction

  // A down-counter loaded with n-1 reaches zero after n edges.
  function automatic int load_of(input int n);
    return (n < 1) ? 0 : n - 1;
  endfunction

  // Width needed to hold values up to n.
  function automatic int width_for(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/udma_dcnt.sv
module udma_dcnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero,
  output logic [W-1:0] val
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      val <= '0;
    else if (load)
      val <= load_val;
    else if (val != '0)
      val <= val - 1'b1;
  end

  assign zero = (val == '0);

endmodule

// File: rtl/udma_term_fsm.sv
module udma_term_fsm
  import udma_term_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     term_req,
  input  logic     xfer_ack,
  input  logic     dev_gone,
  input  logic     ph_zero,
  input  logic     tmo_zero,
  output term_st_e state,
  output logic     take_req,
  output logic     ld_tmo,
  output logic     take_crc,
  output logic     tmo_hit
);

  term_st_e nxt;

  always_comb begin
    nxt      = state;
    take_req = 1'b0;
    ld_tmo   = 1'b0;
    take_crc = 1'b0;
    tmo_hit  = 1'b0;
    unique case (state)
      ST_IDLE: if (term_req && xfer_ack) begin
        take_req = 1'b1;
        nxt      = ST_HOLD;
      end
      ST_HOLD: if (ph_zero) begin
        ld_tmo = 1'b1;
        nxt    = ST_WDEV;
      end
      ST_WDEV: if (dev_gone) begin
        take_crc = 1'b1;
        nxt      = ST_CRC;
      end else if (tmo_zero) begin
        take_crc = 1'b1;
        tmo_hit  = 1'b1;
        nxt      = ST_CRC;
      end
      ST_CRC:  if (ph_zero) nxt = ST_REL;
      ST_REL:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

endmodule

// File: rtl/udma_host_term.sv
module udma_host_term
  import udma_term_pkg::*;
#(
  parameter int DW   = 16,
  parameter int TSS  = 3,
  parameter int TMLI = 4,
  parameter int TDVS = 5,
  parameter int TMO  = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          term_req,
  input  logic          xfer_ack,
  input  logic          xfer_strobe,
  input  logic          dmarq,
  input  logic          ddmardy_n,
  input  logic [DW-1:0] crc_in,
  output logic          hstrobe,
  output logic          stop,
  output logic          dmack_n,
  output logic [DW-1:0] dout,
  output logic          dout_oe,
  output logic          done,
  output logic          dev_timeout
);

  localparam int CRC_WAIT = crc_window(TMLI, TDVS);
  localparam int PH_MAX   = (TSS > CRC_WAIT) ? TSS : CRC_WAIT;
  localparam int PW       = width_for(PH_MAX);
  localparam int TW       = width_for(TMO);

  term_st_e      state;
  logic          take_req, ld_tmo, take_crc, tmo_hit;
  logic          ph_zero, tmo_zero, dev_gone, busy;
  logic          ph_load;
  logic [PW-1:0] ph_load_val, ph_val;
  logic [TW-1:0] tmo_val;
  logic          hs_q, err_q;
  logic [DW-1:0] crc_q;

  // Named events used by the checker
  assign dev_gone = !dmarq && ddmardy_n;
  assign busy     = (state != ST_IDLE);

  udma_term_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .term_req (term_req),
    .xfer_ack (xfer_ack),
    .dev_gone (dev_gone),
    .ph_zero  (ph_zero),
    .tmo_zero (tmo_zero),
    .state    (state),
    .take_req (take_req),
    .ld_tmo   (ld_tmo),
    .take_crc (take_crc),
    .tmo_hit  (tmo_hit)
  );

  // One phase counter serves the setup hold and the CRC window.
  assign ph_load     = take_req || take_crc;
  assign ph_load_val = take_req ? PW'(load_of(TSS)) : PW'(load_of(CRC_WAIT));

  udma_dcnt #(.W(PW)) u_ph (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ph_load),
    .load_val (ph_load_val),
    .zero     (ph_zero),
    .val      (ph_val)
  );

  udma_dcnt #(.W(TW)) u_tmo (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ld_tmo),
    .load_val (TW'(load_of(TMO))),
    .zero     (tmo_zero),
    .val      (tmo_val)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs_q  <= 1'b0;
      crc_q <= '0;
      err_q <= 1'b0;
    end else begin
      if (take_req) hs_q <= xfer_strobe;
      if (take_crc) begin
        hs_q  <= 1'b1;
        crc_q <= crc_in;
      end
      if (tmo_hit) err_q <= 1'b1;
    end
  end

  assign hstrobe     = busy ? hs_q : xfer_strobe;
  assign stop        = (state == ST_WDEV) || (state == ST_CRC) || (state == ST_REL);
  assign dmack_n     = busy ? (state == ST_REL) : !xfer_ack;
  assign dout_oe     = (state == ST_CRC);
  assign dout        = dout_oe ? crc_q : '0;
  assign done        = (state == ST_REL);
  assign dev_timeout = err_q;

endmodule

// File: rtl/udma_term_chk.sv
module udma_term_chk #(
  parameter int WAIT_CYC = 1
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic dev_gone,
  input logic hstrobe,
  input logic stop,
  input logic dmack_n,
  input logic dout_oe,
  input logic done,
  input logic dev_timeout
);

  logic [15:0] oe_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 oe_run <= '0;
    else if (!dout_oe)          oe_run <= '0;
    else if (oe_run != 16'hffff) oe_run <= oe_run + 1'b1;
  end

  AST_STROBE_NO_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> !$fell(hstrobe)); // R3

  AST_STOP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (stop && !done) |=> stop); // R4

  AST_CRC_AFTER_DEVICE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_oe) |-> ($past(dev_gone) || dev_timeout)); // R5

  AST_OE_UNDER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> !dmack_n); // R6

  AST_CRC_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (oe_run == 16'(WAIT_CYC))); // R6

  AST_RELEASE_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (stop && hstrobe && dmack_n && !dout_oe)); // R7

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    dev_timeout |=> dev_timeout); // R8

endmodule

bind udma_host_term udma_term_chk #(.WAIT_CYC(CRC_WAIT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .busy        (busy),
  .dev_gone    (dev_gone),
  .hstrobe     (hstrobe),
  .stop        (stop),
  .dmack_n     (dmack_n),
  .dout_oe     (dout_oe),
  .done        (done),
  .dev_timeout (dev_timeout)
);

// File: tb/sim_udma_host_term.sv
`timescale 1ns/1ps
module sim_udma_host_term;

  localparam int DW   = 16;
  localparam int TSS  = 3;
  localparam int TMLI = 4;
  localparam int TDVS = 5;
  localparam int TMO  = 24;
  localparam int WIN  = (TMLI > TDVS) ? TMLI : TDVS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic term_req = 1'b0, xfer_ack = 1'b0, xfer_strobe = 1'b0;
  logic dmarq = 1'b0, ddmardy_n = 1'b1;
  logic [DW-1:0] crc_in = '0;
  logic hstrobe, stop, dmack_n, dout_oe, done, dev_timeout;
  logic [DW-1:0] dout;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  always #2 clk = ~clk;

  udma_host_term #(.DW(DW), .TSS(TSS), .TMLI(TMLI), .TDVS(TDVS), .TMO(TMO)) u0 (
    .clk(clk), .rst_n(rst_n), .term_req(term_req), .xfer_ack(xfer_ack),
    .xfer_strobe(xfer_strobe), .dmarq(dmarq), .ddmardy_n(ddmardy_n),
    .crc_in(crc_in), .hstrobe(hstrobe), .stop(stop), .dmack_n(dmack_n),
    .dout(dout), .dout_oe(dout_oe), .done(done), .dev_timeout(dev_timeout)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  // Behavioural reference: phase name, elapsed counts, captured values
  string m_ph = "idle";
  int    m_k = 0;
  bit    m_hs = 1'b0, m_err = 1'b0;
  logic [DW-1:0] m_crc = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = "idle"; m_k = 0; m_hs = 1'b0; m_err = 1'b0; m_crc = '0;
    end else begin
      if (m_ph == "idle") begin
        if (term_req && xfer_ack) begin m_ph = "hold"; m_hs = xfer_strobe; m_k = 0; end
      end else if (m_ph == "hold") begin
        m_k++;
        if (m_k == TSS) begin m_ph = "dev"; m_k = 0; end
      end else if (m_ph == "dev") begin
        m_k++;
        if (!dmarq && ddmardy_n) begin
          m_ph = "crc"; m_k = 0; m_hs = 1'b1; m_crc = crc_in;
        end else if (m_k == TMO) begin
          m_ph = "crc"; m_k = 0; m_hs = 1'b1; m_crc = crc_in; m_err = 1'b1;
        end
      end else if (m_ph == "crc") begin
        m_k++;
        if (m_k == WIN) m_ph = "rel";
      end else begin
        m_ph = "idle";
      end
    end
  end

  // Compare every output on the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      bit idle;
      idle = (m_ph == "idle");
      check(idle ? "R9" : "R3", "hstrobe", 32'(hstrobe), idle ? 32'(xfer_strobe) : 32'(m_hs));
      check(idle ? "R9" : "R4", "stop", 32'(stop), 32'(m_ph == "dev" || m_ph == "crc" || m_ph == "rel"));
      check(idle ? "R9" : "R7", "dmack_n", 32'(dmack_n), idle ? 32'(!xfer_ack) : 32'(m_ph == "rel"));
      check("R6", "dout_oe", 32'(dout_oe), 32'(m_ph == "crc"));
      check("R6", "dout", 32'(dout), (m_ph == "crc") ? 32'(m_crc) : 32'h0);
      check("R7", "done", 32'(done), 32'(m_ph == "rel"));
      check("R8", "dev_timeout", 32'(dev_timeout), 32'(m_err));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected<150000 cycles", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic step(); @(posedge clk); #1; endtask

  task automatic burst(input int ntog, input int d1, input int d2,
                       input bit ready_first, input bit hang, input bit poke);
    step();
    xfer_ack = 1'b1; dmarq = 1'b1; ddmardy_n = 1'b0;
    crc_in = 16'($urandom);
    for (int i = 0; i < ntog; i++) begin step(); xfer_strobe = ~xfer_strobe; end
    step(); term_req = 1'b1;
    step(); term_req = 1'b0;
    if (poke) begin xfer_strobe = ~xfer_strobe; step(); term_req = 1'b1; step(); term_req = 1'b0; end // R2 R3
    while (!stop) step();
    if (!hang) begin
      repeat (d1) step();
      if (ready_first) ddmardy_n = 1'b1; else dmarq = 1'b0;
      repeat (d2) step();
      dmarq = 1'b0; ddmardy_n = 1'b1; // R5
    end
    while (!done) step();
    step();
    xfer_ack = 1'b0; dmarq = 1'b0; ddmardy_n = 1'b1;
    step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1", "hstrobe", 32'(hstrobe), 0);
    check("R1", "stop", 32'(stop), 0);
    check("R1", "dmack_n", 32'(dmack_n), 1);
    check("R1", "dout_oe/dout/done", {dout_oe, done, 14'h0, dout}, 0);
    check("R1", "dev_timeout", 32'(dev_timeout), 0);
    rst_n = 1'b1;
    step();
    // R2: request without acknowledge is ignored
    term_req = 1'b1; xfer_strobe = 1'b1;
    repeat (4) step();
    term_req = 1'b0;
    check("R2", "stop after ignored request", 32'(stop), 0);
    check("R2", "hstrobe pass-through", 32'(hstrobe), 1);
    xfer_strobe = 1'b0;
    // Directed bursts: strobe low and high at termination
    burst(2, 0, 0, 1'b0, 1'b0, 1'b0);
    burst(3, 2, 3, 1'b1, 1'b0, 1'b1);
    check("R8", "no flag after normal bursts", 32'(dev_timeout), 0);
    // R8: device never withdraws
    burst(1, 0, 0, 1'b0, 1'b1, 1'b0);
    check("R8", "flag after timeout burst", 32'(dev_timeout), 1);
    // Random bursts
    for (int b = 0; b < 40; b++)
      burst($urandom_range(0, 5), $urandom_range(0, 8), $urandom_range(0, 6),
            1'($urandom_range(0, 1)), 1'b0, 1'($urandom_range(0, 1)));
    check("R8", "flag remains sticky", 32'(dev_timeout), 1);
    check("R9", "idle stop", 32'(stop), 0);
    repeat (4) step();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule